// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Decimal-Aware Flags

A purely combinational 8-bit arithmetic and logic unit for a small accumulator-based processor. Each evaluation takes the accumulator, a second operand, the current carry and a 4-bit operation code. It returns an 8-bit result and a result write enable. It also returns a packed flag byte and a 5-bit set of per-flag update enables. The surrounding datapath writes the result back only when the write enable is high. It updates only the flags whose enables are high.

The flag byte carries sign, zero, nibble (half) carry, even parity and carry at fixed positions. It also holds three constant bits. The nibble carry is the carry out of bit 3, which decimal-correction software uses. Compare runs a subtraction that only touches flags. The rotates touch only the carry. Complement accumulator touches no flag, and complement carry changes only the carry.

Top module: `alu8_flags`

## Requirements
- R1: `flags_o` is packed as bit 7 S, bit 6 Z, bit 5 constant 0, bit 4 AC, bit 3 constant 0, bit 2 P, bit 1 constant 1, bit 0 CY, for every operation. `flag_we_o` bits are 4 S, 3 Z, 2 AC, 1 P, 0 CY.
- R2: Op 0 (add) and op 1 (add with carry, which adds `cy_i`) give the low 8 bits of the sum. CY is the carry out of bit 7, all five flags are enabled and the write enable is 1.
- R3: Op 2 (subtract) and op 3 (subtract with borrow, which also subtracts `cy_i`) give the low 8 bits of the difference. CY is 1 when the operands plus borrow exceed the accumulator. All five flags are enabled and the write enable is 1.
- R4: For the arithmetic ops and compare, AC is the carry out of bit 3. For addition this is computed on a + b + carry-in. For subtraction it is computed on a + ~b + (1 - borrow-in).
- R5: Whenever S, Z or P are enabled, S equals result bit 7, Z is 1 exactly when the result is zero, and P is 1 exactly when the result has an even number of one bits.
- R6: Ops 4 (AND), 5 (XOR) and 6 (OR) give the bitwise result with CY=0 and AC=0. All five flags are enabled and the write enable is 1.
- R7: Op 7 (compare) sets all five flags as subtract would and outputs the difference, with the write enable at 0. Z=1 means the values are equal; otherwise CY=1 means the accumulator is the smaller value.
- R8: Op 8 rotates left, with bit 7 going to bit 0 and to CY. Op 9 rotates right, with bit 0 going to bit 7 and to CY. Only the CY enable is set, and the write enable is 1.
- R9: Op 10 rotates left through carry, with old CY going to bit 0 and bit 7 going to CY. Op 11 rotates right through carry, with old CY going to bit 7 and bit 0 going to CY. Only the CY enable is set, and the write enable is 1.
- R10: Op 12 outputs the inverted accumulator with no flag enables and the write enable at 1. Op 13 sets CY to the inverse of `cy_i`, with only the CY enable set and the write enable at 0.
- R11: Op codes 14 and 15 assert neither the write enable nor any flag enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| cy_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| result_o | output | 8 | Operation result |
| res_we_o | output | 1 | Result write enable |
| flags_o | output | 8 | Packed flag byte |
| flag_we_o | output | 5 | Per-flag update enables (S,Z,AC,P,CY) |

## Verification
The hardest case to reach is the nibble carry under borrow. It differs from the plain carry only when the low nibbles straddle each other and the incoming borrow tips the balance. Random pairs rarely land there with the carry in both states. The bench therefore sweeps every accumulator value against sixteen operands that cover all low-nibble values, once with each carry value, for every op code. This puts every low-nibble pair at both borrow settings.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 4;
  localparam int FWE_W  = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_AND = 4'd4,  OP_XOR = 4'd5,  OP_OR  = 4'd6,  OP_CMP = 4'd7,
    OP_RLC = 4'd8,  OP_RRC = 4'd9,  OP_RAL = 4'd10, OP_RAR = 4'd11,
    OP_CMA = 4'd12, OP_CMC = 4'd13, OP_RS0 = 4'd14, OP_RS1 = 4'd15
  } alu_op_e;

  // flag byte positions
  localparam int FB_S = 7, FB_Z = 6, FB_AC = 4, FB_P = 2, FB_CY = 0;
  // update enable positions
  localparam int FE_S = 4, FE_Z = 3, FE_AC = 2, FE_P = 1, FE_CY = 0;

  localparam logic [FWE_W-1:0] FWE_ALL  = '1;
  localparam logic [FWE_W-1:0] FWE_CY   = 5'b00001;
  localparam logic [FWE_W-1:0] FWE_NONE = '0;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int W = DATA_W,
  localparam int NW = W / 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,   // carry (add) or borrow (sub)
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         ac_o
);
  logic [W-1:0]  b_eff;
  logic          cin_eff;
  logic [NW:0]   lo_sum;
  logic [W:0]    full_sum;

  always_comb begin
    b_eff    = sub_i ? ~b_i : b_i;
    cin_eff  = sub_i ? ~cin_i : cin_i;
    lo_sum   = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, cin_eff};
    full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
    sum_o    = full_sum[W-1:0];
    ac_o     = lo_sum[NW];
    cy_o     = sub_i ? ~full_sum[W] : full_sum[W];  // borrow is inverted carry
  end
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic         cy_i,
  input  logic         left_i,
  input  logic         thru_i,  // rotate through carry
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  logic fill;

  always_comb begin
    if (left_i) begin
      fill  = thru_i ? cy_i : a_i[W-1];
      res_o = {a_i[W-2:0], fill};
      cy_o  = a_i[W-1];
    end else begin
      fill  = thru_i ? cy_i : a_i[0];
      res_o = {fill, a_i[W-1:1]};
      cy_o  = a_i[0];
    end
  end
endmodule

// File: rtl/alu8_flag_pack.sv
module alu8_flag_pack
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] res_i,
  input  logic         cy_i,
  input  logic         ac_i,
  output logic [7:0]   flags_o
);
  logic [W-1:0] par_chain;

  // ripple parity, bit W-1 holds xor of all bits
  assign par_chain[0] = res_i[0];
  for (genvar g = 1; g < W; g++) begin : g_par
    assign par_chain[g] = par_chain[g-1] ^ res_i[g];
  end

  always_comb begin
    flags_o        = 8'b0000_0010;
    flags_o[FB_S]  = res_i[W-1];
    flags_o[FB_Z]  = (res_i == '0);
    flags_o[FB_AC] = ac_i;
    flags_o[FB_P]  = ~par_chain[W-1];
    flags_o[FB_CY] = cy_i;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  input  logic       cy_i,
  input  logic [3:0] op_i,
  output logic [7:0] result_o,
  output logic       res_we_o,
  output logic [7:0] flags_o,
  output logic [4:0] flag_we_o
);
  alu_op_e      op;
  logic         as_sub, as_cin;
  logic [7:0]   as_sum, rot_res;
  logic         as_cy, as_ac, rot_cy;
  logic [7:0]   res;
  logic         cy_new, ac_new;

  assign op     = alu_op_e'(op_i);
  assign as_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  assign as_cin = ((op == OP_ADC) || (op == OP_SBB)) & cy_i;

  alu8_addsub #(.W(DATA_W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(as_sub), .cin_i(as_cin),
    .sum_o(as_sum), .cy_o(as_cy), .ac_o(as_ac)
  );

  alu8_rotate #(.W(DATA_W)) u_rotate (
    .a_i(a_i), .cy_i(cy_i),
    .left_i(~op_i[0]), .thru_i(op_i[1]),
    .res_o(rot_res), .cy_o(rot_cy)
  );

  always_comb begin
    res       = a_i;
    cy_new    = cy_i;
    ac_new    = 1'b0;
    res_we_o  = 1'b1;
    flag_we_o = FWE_ALL;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        res    = as_sum;
        cy_new = as_cy;
        ac_new = as_ac;
        if (op == OP_CMP) res_we_o = 1'b0;
      end
      OP_AND: begin res = a_i & b_i; cy_new = 1'b0; end
      OP_XOR: begin res = a_i ^ b_i; cy_new = 1'b0; end
      OP_OR:  begin res = a_i | b_i; cy_new = 1'b0; end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        res       = rot_res;
        cy_new    = rot_cy;
        flag_we_o = FWE_CY;
      end
      OP_CMA: begin
        res       = ~a_i;
        flag_we_o = FWE_NONE;
      end
      OP_CMC: begin
        cy_new    = ~cy_i;
        res_we_o  = 1'b0;
        flag_we_o = FWE_CY;
      end
      default: begin
        res_we_o  = 1'b0;
        flag_we_o = FWE_NONE;
      end
    endcase
  end

  assign result_o = res;

  alu8_flag_pack #(.W(DATA_W)) u_flag_pack (
    .res_i(res), .cy_i(cy_new), .ac_i(ac_new), .flags_o(flags_o)
  );
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic [7:0] a_i,
  input logic [7:0] b_i,
  input logic       cy_i,
  input logic [3:0] op_i,
  input logic [7:0] result_o,
  input logic       res_we_o,
  input logic [7:0] flags_o,
  input logic [4:0] flag_we_o
);
  always_comb begin
    // R1
    const_bits_chk: assert (flags_o[5] == 1'b0 && flags_o[3] == 1'b0 && flags_o[1] == 1'b1);
    // R5
    if (flag_we_o[3]) zero_flag_chk: assert (flags_o[6] == (result_o == 8'd0));
    // R5
    if (flag_we_o[1]) parity_flag_chk: assert (flags_o[2] == ($countones(result_o) % 2 == 0));
    // R6
    if (op_i inside {4'd4, 4'd5, 4'd6}) logic_cy_chk: assert (flags_o[0] == 1'b0 && flags_o[4] == 1'b0);
    // R7
    if (op_i == 4'd7) cmp_no_write_chk: assert (!res_we_o && flag_we_o == 5'b11111);
    // R7
    if (op_i == 4'd7 && flags_o[6]) cmp_equal_chk: assert (a_i == b_i);
    // R8
    if (op_i inside {[4'd8:4'd11]}) rot_only_cy_chk: assert (flag_we_o == 5'b00001 && res_we_o);
    // R10
    if (op_i == 4'd12) cma_no_flags_chk: assert (flag_we_o == 5'b0 && result_o == ~a_i);
    // R10
    if (op_i == 4'd13) cmc_invert_chk: assert (flags_o[0] != cy_i && flag_we_o == 5'b00001);
    // R11
    if (op_i >= 4'd14) unused_op_chk: assert (!res_we_o && flag_we_o == 5'b0);
  end
endmodule

bind alu8_flags alu8_flags_chk u_alu8_flags_chk (
  .a_i(a_i), .b_i(b_i), .cy_i(cy_i), .op_i(op_i),
  .result_o(result_o), .res_we_o(res_we_o),
  .flags_o(flags_o), .flag_we_o(flag_we_o)
);

// File: tb/alu8_flags_bench.sv
`timescale 1ns/1ps
module alu8_flags_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] a_i, b_i, result_o, flags_o;
  logic       cy_i, res_we_o;
  logic [3:0] op_i;
  logic [4:0] flag_we_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  alu8_flags u_alu8_flags (
    .a_i(a_i), .b_i(b_i), .cy_i(cy_i), .op_i(op_i),
    .result_o(result_o), .res_we_o(res_we_o),
    .flags_o(flags_o), .flag_we_o(flag_we_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s op=%0d a=%0d b=%0d cy=%0d actual=%0d expected=%0d",
               req, what, op_i, a_i, b_i, cy_i, act, exp);
    end
  endtask

  function automatic string op_req(input int op);
    case (op)
      0, 1:           return "R2";
      2, 3:           return "R3";
      4, 5, 6:        return "R6";
      7:              return "R7";
      8, 9:           return "R8";
      10, 11:         return "R9";
      12, 13:         return "R10";
      default:        return "R11";
    endcase
  endfunction

  task automatic check_vec(input int op, input int a, input int b, input int c);
    int e_res, e_we, e_fwe, e_cy, e_ac, s, lo;
    string rq;
    bit chk_res;
    rq = op_req(op);
    e_res = a; e_we = 1; e_fwe = 31; e_cy = c; e_ac = 0; chk_res = 1'b1;
    case (op)
      0, 1: begin
        s = a + b + ((op == 1) ? c : 0);
        lo = (a & 15) + (b & 15) + ((op == 1) ? c : 0);
        e_res = s & 255; e_cy = (s > 255); e_ac = (lo > 15);
      end
      2, 3, 7: begin
        s = a - b - ((op == 3) ? c : 0);
        lo = (a & 15) + ((~b) & 15) + 1 - ((op == 3) ? c : 0);
        e_res = s & 255; e_cy = (s < 0); e_ac = (lo > 15);
        if (op == 7) e_we = 0;
      end
      4: begin e_res = a & b; e_cy = 0; end
      5: begin e_res = a ^ b; e_cy = 0; end
      6: begin e_res = a | b; e_cy = 0; end
      8:  begin e_res = ((a << 1) | (a >> 7)) & 255; e_cy = a >> 7; e_fwe = 1; end
      9:  begin e_res = ((a >> 1) | (a << 7)) & 255; e_cy = a & 1;  e_fwe = 1; end
      10: begin e_res = ((a << 1) | c) & 255;        e_cy = a >> 7; e_fwe = 1; end
      11: begin e_res = (a >> 1) | (c << 7);         e_cy = a & 1;  e_fwe = 1; end
      12: begin e_res = 255 - a; e_fwe = 0; end
      13: begin e_cy = 1 - c; e_we = 0; e_fwe = 1; chk_res = 1'b0; end
      default: begin e_we = 0; e_fwe = 0; chk_res = 1'b0; end
    endcase
    // R1 constant bits
    chk(flags_o[5] == 0 && flags_o[3] == 0 && flags_o[1] == 1, "R1", "const",
        int'(flags_o), 2);
    chk(res_we_o == e_we[0], rq, "we", int'(res_we_o), e_we);
    chk(flag_we_o == e_fwe[4:0], rq, "flag_we", int'(flag_we_o), e_fwe);
    if (chk_res) chk(result_o == e_res[7:0], rq, "result", int'(result_o), e_res);
    if (e_fwe[0]) chk(flags_o[0] == e_cy[0], rq, "CY", int'(flags_o[0]), e_cy);
    if (e_fwe[2])
      chk(flags_o[4] == e_ac[0], (op >= 4 && op <= 6) ? "R6" : "R4", "AC",
          int'(flags_o[4]), e_ac);
    if (e_fwe[4])
      chk(flags_o[7] == e_res[7], "R5", "S", int'(flags_o[7]), e_res[7]);
    if (e_fwe[3])
      chk(flags_o[6] == (e_res == 0), "R5", "Z", int'(flags_o[6]), int'(e_res == 0));
    if (e_fwe[1])
      chk(flags_o[2] == ($countones(e_res[7:0]) % 2 == 0), "R5", "P",
          int'(flags_o[2]), int'($countones(e_res[7:0]) % 2 == 0));
    // R7 compare ordering: A smaller exactly when CY set and Z clear
    if (op == 7)
      chk((flags_o[0] && !flags_o[6]) == (a < b), "R7", "order",
          int'(flags_o[0]), int'(a < b));
  endtask

  initial begin
    a_i = '0; b_i = '0; cy_i = 1'b0; op_i = '0;
    for (int op = 0; op < 16; op++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 256; a++)
          for (int bi = 0; bi < 16; bi++) begin
            @(negedge clk);
            op_i = op[3:0]; a_i = a[7:0]; b_i = 8'((bi * 17) ^ (a & 8'h30));
            cy_i = c[0];
            #1;
            check_vec(op, a, int'(b_i), c);
          end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule